// File: doc/BRIEF.md
# Video Timing Controller Register Readback Decoder

This block is the processor-side register file of a cathode-ray-tube timing controller. It stores the sixteen writable timing registers and the two read-only light-pen address registers. It returns a read data byte whose value depends on which of five chip variants is selected. The variants differ in several ways: which registers can be read at all, whether the register index is decoded in full or only in its low three bits, what a read through the status path returns, and whether reading the light-pen registers has a side effect on the status flag. Video timing generation is not part of this block.

A light-pen strobe captures the current display address into the two light-pen registers and raises the light-pen flag. That flag is bit 6 of the status byte. Every other status bit reads 0. A read request is sampled on a rising clock edge, and the data appears on the next cycle together with a valid pulse.

Top module: `vtc_readback`

## Requirements
- R1: After synchronous reset, every stored register, both light-pen registers and the light-pen flag are 0, and `rd_data_o` and `rd_valid_o` are 0.
- R2: A write stores only the implemented bits of the addressed register, and unimplemented bits read as 0. Registers 12 and 14 hold 6 bits, and registers 13 and 15 hold 8 bits. A write to an index of 16 or above changes nothing.
- R3: `rd_valid_o` is high exactly in the cycle after a cycle in which `rd_en_i` was high, and `rd_data_o` carries the result of that read.
- R4: Variant 0, register path: indices 12 to 15 return the stored registers, 16 returns the high light-pen byte, 17 returns the low light-pen byte, and every other index returns 0.
- R5: Variants 1 and 2, register path: indices 14 to 17 are readable as in R4, and every other index, including 12 and 13, returns 0.
- R6: Variants 3 and 4 decode only the low 3 bits of the index. The mapping is 0 to the high light-pen byte, 1 to the low light-pen byte, 4 to 7 to registers 12 to 15. As a result, indices 4, 12 and 20 return the same value.
- R7: On variants 3 and 4, low index bits 2 and 3 return the status byte instead of the cursor raster registers. Those registers still accept writes.
- R8: A light-pen strobe loads display address bits 13:8 into the high light-pen byte, with its upper two bits 0, loads bits 7:0 into the low byte, and sets the status flag (bit 6).
- R9: On variant 1 only, a register-path read of index 16 or 17 clears the light-pen flag at the read edge. Reads on any other variant leave the flag set.
- R10: Status path (`stat_sel_i` high on a read): variant 1 returns the status byte, variants 3 and 4 return the same value as the register path, and variants 0 and 2 return 0. A status read never clears the flag.
- R11: When a light-pen strobe and a clearing read fall in the same cycle, the flag ends up set and the read returns the light-pen value held before the strobe.
- R12: Variant codes 5 to 7 behave exactly like variant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_i | input | 3 | Chip variant select (0 to 4; 5 to 7 act as 0) |
| reg_idx_i | input | IDX_W (5) | Register index for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW (8) | Write data |
| rd_en_i | input | 1 | Read strobe |
| stat_sel_i | input | 1 | Read goes through the status path |
| pen_strobe_i | input | 1 | Light-pen capture strobe |
| disp_addr_i | input | AW (14) | Current display address |
| rd_data_o | output | DW (8) | Read data, valid the cycle after the read |
| rd_valid_o | output | 1 | Read data valid pulse |

## Verification
The same stored contents are read back under every variant. Readable registers must return their data, and non-readable ones must return 0, which separates the full-index variants from one another. Indices 4, 12, 20 and 31 are read on the aliasing variants, and the same indices read as 0 or differently on variant 0, which separates three-bit decoding from full decoding. The flag is probed before and after reads of the light-pen registers on each variant, which separates the clearing variant from the others. A strobe coinciding with a clearing read checks the set-over-clear ordering and the old-value return.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    typedef enum logic [2:0] {
        VAR0 = 3'd0,
        VAR1 = 3'd1,
        VAR2 = 3'd2,
        VAR3 = 3'd3,
        VAR4 = 3'd4
    } variant_e;

    localparam int PEN_FLAG_BIT = 6;

    // Map any 3-bit code onto a known variant; unused codes fall back to 0.
    function automatic variant_e norm_variant(input logic [2:0] code);
        variant_e v;
        case (code)
            3'd1:    v = VAR1;
            3'd2:    v = VAR2;
            3'd3:    v = VAR3;
            3'd4:    v = VAR4;
            default: v = VAR0;
        endcase
        return v;
    endfunction

    // Implemented-bit mask of each stored register.
    function automatic logic [7:0] impl_mask(input int idx);
        logic [7:0] m;
        case (idx)
            4, 6, 7, 10: m = 8'h7F;
            5, 9, 11:    m = 8'h1F;
            12, 14:      m = 8'h3F;
            default:     m = 8'hFF;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] status_byte(input logic flag);
        logic [7:0] s;
        s = '0;
        s[PEN_FLAG_BIT] = flag;
        return s;
    endfunction

endpackage

// File: rtl/vtc_regbank.sv
module vtc_regbank #(
    parameter int NREG  = 16,
    parameter int IDX_W = 5,
    parameter int DW    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic [NREG-1:0][DW-1:0]   regs
);
    import vtc_pkg::*;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] MASK = DW'(impl_mask(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                regs[g] <= wr_data & MASK;
            end
        end
    end

endmodule

// File: rtl/vtc_pen_latch.sv
module vtc_pen_latch #(
    parameter int AW = 14,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [AW-1:0] addr,
    input  logic          clr_req,
    output logic [DW-1:0] pen_hi,
    output logic [DW-1:0] pen_lo,
    output logic          flag
);
    localparam int HI_W = AW - DW;

    always_ff @(posedge clk) begin
        if (rst) begin
            pen_hi <= '0;
            pen_lo <= '0;
        end else if (strobe) begin
            pen_hi <= {{(DW-HI_W){1'b0}}, addr[AW-1:DW]};
            pen_lo <= addr[DW-1:0];
        end
    end

    // A new capture outranks a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (strobe) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/vtc_rd_decode.sv
module vtc_rd_decode #(
    parameter int NREG  = 16,
    parameter int IDX_W = 5,
    parameter int DW    = 8
) (
    input  vtc_pkg::variant_e        variant,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     rd_en,
    input  logic                     stat_sel,
    input  logic [NREG-1:0][DW-1:0]  regs,
    input  logic [DW-1:0]            pen_hi,
    input  logic [DW-1:0]            pen_lo,
    input  logic                     flag,
    output logic [DW-1:0]            data,
    output logic                     clr_req
);
    import vtc_pkg::*;

    localparam int IDX_PEN_HI = 16;
    localparam int IDX_PEN_LO = 17;

    logic [DW-1:0] status;
    logic [DW-1:0] reg_path;
    int            full_idx;

    assign status   = DW'(status_byte(flag));
    assign full_idx = int'(idx);

    always_comb begin
        reg_path = '0;
        unique case (variant)
            VAR3, VAR4: begin
                unique case (idx[2:0])
                    3'd0:    reg_path = pen_hi;
                    3'd1:    reg_path = pen_lo;
                    3'd2,
                    3'd3:    reg_path = status;
                    default: reg_path = regs[12 + int'(idx[1:0])];
                endcase
            end
            VAR1, VAR2: begin
                if (full_idx == IDX_PEN_HI)      reg_path = pen_hi;
                else if (full_idx == IDX_PEN_LO) reg_path = pen_lo;
                else if (full_idx == 14 || full_idx == 15)
                    reg_path = regs[full_idx[3:0]];
            end
            default: begin
                if (full_idx == IDX_PEN_HI)      reg_path = pen_hi;
                else if (full_idx == IDX_PEN_LO) reg_path = pen_lo;
                else if (full_idx >= 12 && full_idx <= 15)
                    reg_path = regs[full_idx[3:0]];
            end
        endcase
    end

    always_comb begin
        if (!stat_sel) begin
            data = reg_path;
        end else begin
            unique case (variant)
                VAR1:       data = status;
                VAR3, VAR4: data = reg_path;
                default:    data = '0;
            endcase
        end
    end

    assign clr_req = rd_en && !stat_sel && (variant == VAR1) &&
                     (full_idx == IDX_PEN_HI || full_idx == IDX_PEN_LO);

endmodule

// File: rtl/vtc_readback.sv
module vtc_readback #(
    parameter int IDX_W = 5,
    parameter int DW    = 8,
    parameter int AW    = 14,
    parameter int NREG  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       variant_i,
    input  logic [IDX_W-1:0] reg_idx_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             rd_en_i,
    input  logic             stat_sel_i,
    input  logic             pen_strobe_i,
    input  logic [AW-1:0]    disp_addr_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o
);
    import vtc_pkg::*;

    variant_e                 variant;
    logic [NREG-1:0][DW-1:0]  regs;
    logic [DW-1:0]            pen_hi;
    logic [DW-1:0]            pen_lo;
    logic                     pen_flag;
    logic [DW-1:0]            dec_data;
    logic                     clr_req;

    assign variant = norm_variant(variant_i);

    vtc_regbank #(.NREG(NREG), .IDX_W(IDX_W), .DW(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_idx  (reg_idx_i),
        .wr_data (wr_data_i),
        .regs    (regs)
    );

    vtc_pen_latch #(.AW(AW), .DW(DW)) u_pen (
        .clk     (clk),
        .rst     (rst),
        .strobe  (pen_strobe_i),
        .addr    (disp_addr_i),
        .clr_req (clr_req),
        .pen_hi  (pen_hi),
        .pen_lo  (pen_lo),
        .flag    (pen_flag)
    );

    vtc_rd_decode #(.NREG(NREG), .IDX_W(IDX_W), .DW(DW)) u_dec (
        .variant  (variant),
        .idx      (reg_idx_i),
        .rd_en    (rd_en_i),
        .stat_sel (stat_sel_i),
        .regs     (regs),
        .pen_hi   (pen_hi),
        .pen_lo   (pen_lo),
        .flag     (pen_flag),
        .data     (dec_data),
        .clr_req  (clr_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) begin
                rd_data_o <= dec_data;
            end
        end
    end

endmodule

// File: rtl/vtc_readback_chk.sv
module vtc_readback_chk #(
    parameter int IDX_W = 5,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       variant_i,
    input logic [IDX_W-1:0] reg_idx_i,
    input logic             rd_en_i,
    input logic             stat_sel_i,
    input logic             pen_strobe_i,
    input logic [DW-1:0]    rd_data_o,
    input logic             rd_valid_o,
    input logic             pen_flag
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data_o == '0 && !rd_valid_o));

    // R3
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    // R3
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> !rd_valid_o);

    // R8
    strobe_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        pen_strobe_i |=> pen_flag);

    // R9
    flag_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (pen_flag && variant_i != 3'd1) |=> pen_flag);

    // R4
    v0_hidden_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !stat_sel_i && variant_i == 3'd0 && int'(reg_idx_i) < 12)
        |=> rd_data_o == '0);

    // R5
    v1_hidden_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !stat_sel_i && (variant_i == 3'd1 || variant_i == 3'd2) &&
         int'(reg_idx_i) < 14) |=> rd_data_o == '0);

    // R10
    stat_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && stat_sel_i && (variant_i == 3'd0 || variant_i == 3'd2))
        |=> rd_data_o == '0);

endmodule

bind vtc_readback vtc_readback_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .variant_i    (variant_i),
    .reg_idx_i    (reg_idx_i),
    .rd_en_i      (rd_en_i),
    .stat_sel_i   (stat_sel_i),
    .pen_strobe_i (pen_strobe_i),
    .rd_data_o    (rd_data_o),
    .rd_valid_o   (rd_valid_o),
    .pen_flag     (pen_flag)
);

// File: tb/vtc_readback_bench.sv
module vtc_readback_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] variant_i = '0;
    logic [4:0] reg_idx_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_en_i = 1'b0;
    logic       stat_sel_i = 1'b0;
    logic       pen_strobe_i = 1'b0;
    logic [13:0] disp_addr_i = '0;
    logic [7:0] rd_data_o;
    logic       rd_valid_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    vtc_readback u_vtc_readback (
        .clk          (clk),
        .rst          (rst),
        .variant_i    (variant_i),
        .reg_idx_i    (reg_idx_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .rd_en_i      (rd_en_i),
        .stat_sel_i   (stat_sel_i),
        .pen_strobe_i (pen_strobe_i),
        .disp_addr_i  (disp_addr_i),
        .rd_data_o    (rd_data_o),
        .rd_valid_o   (rd_valid_o)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx_i = 5'(idx);
        wr_data_i = d;
        wr_en_i   = 1'b1;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    // Driver: issues one read and pushes its expected byte.
    task automatic rd(input int var_code, input int idx, input bit stat,
                      input logic [7:0] exp, input string tag);
        @(negedge clk);
        variant_i  = 3'(var_code);
        reg_idx_i  = 5'(idx);
        stat_sel_i = stat;
        rd_en_i    = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en_i    = 1'b0;
        stat_sel_i = 1'b0;
    endtask

    task automatic pen(input logic [13:0] a);
        @(negedge clk);
        disp_addr_i  = a;
        pen_strobe_i = 1'b1;
        @(negedge clk);
        pen_strobe_i = 1'b0;
    endtask

    // Monitor: pops and compares every returned byte.
    always @(negedge clk) begin
        if (!rst && rd_valid_o) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R3: valid without read, got 0x%02h expected none", rd_data_o);
            end else begin
                check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rd_data", rd_data_o, 8'h00);
        check("R1 rd_valid", {7'b0, rd_valid_o}, 8'h00);
        rd(0, 16, 0, 8'h00, "R1 pen hi");
        rd(3, 2, 0, 8'h00, "R1 flag");
        rd(0, 13, 0, 8'h00, "R1 reg13");

        // R2 masked writes
        wr(12, 8'hFF);
        wr(13, 8'hA5);
        wr(14, 8'hC7);
        wr(15, 8'h5A);
        wr(10, 8'h77);
        wr(20, 8'h99);
        wr(17, 8'h66);

        // R4 variant 0
        rd(0, 12, 0, 8'h3F, "R2 R4 reg12 mask");
        rd(0, 13, 0, 8'hA5, "R4 reg13");
        rd(0, 14, 0, 8'h07, "R2 R4 reg14 mask");
        rd(0, 15, 0, 8'h5A, "R4 reg15");
        rd(0, 17, 0, 8'h00, "R2 R4 write to 17 ignored");
        rd(0, 5, 0, 8'h00, "R4 idx5 zero");
        rd(0, 10, 0, 8'h00, "R4 idx10 zero");
        rd(0, 20, 0, 8'h00, "R4 idx20 zero");

        // R5 variants 1 and 2
        rd(1, 12, 0, 8'h00, "R5 v1 reg12 hidden");
        rd(2, 13, 0, 8'h00, "R5 v2 reg13 hidden");
        rd(1, 14, 0, 8'h07, "R5 v1 reg14");
        rd(2, 15, 0, 8'h5A, "R5 v2 reg15");
        rd(1, 0, 0, 8'h00, "R5 v1 idx0");

        // R6 aliasing, back to back
        rd(3, 4, 0, 8'h3F, "R6 idx4");
        rd(3, 12, 0, 8'h3F, "R6 idx12");
        rd(4, 20, 0, 8'h3F, "R6 R2 idx20");
        rd(4, 5, 0, 8'hA5, "R6 idx5");
        rd(3, 6, 0, 8'h07, "R6 idx6");
        rd(3, 31, 0, 8'h5A, "R6 idx31");

        // R8 capture
        pen(14'h2ABC);
        rd(3, 0, 0, 8'h2A, "R8 R6 pen hi");
        rd(4, 9, 0, 8'hBC, "R8 R6 pen lo alias");
        rd(3, 2, 0, 8'h40, "R7 R8 flag via idx2");
        rd(4, 11, 0, 8'h40, "R7 idx11 status");
        rd(0, 16, 0, 8'h2A, "R4 pen hi");
        rd(0, 17, 0, 8'hBC, "R4 pen lo");
        rd(2, 17, 0, 8'hBC, "R5 v2 pen lo");
        rd(3, 3, 0, 8'h40, "R9 flag kept after v0 v2 reads");

        // R10 status path and R9 clear
        rd(1, 0, 1, 8'h40, "R10 v1 status");
        rd(1, 0, 1, 8'h40, "R10 status read keeps flag");
        rd(1, 17, 0, 8'hBC, "R9 v1 pen lo");
        rd(1, 5, 1, 8'h00, "R9 flag cleared");
        rd(3, 2, 0, 8'h00, "R9 flag cleared v3 view");
        rd(0, 13, 1, 8'h00, "R10 v0 status zero");
        rd(2, 13, 1, 8'h00, "R10 v2 status zero");
        rd(3, 5, 1, 8'hA5, "R10 v3 status path reg");
        rd(4, 1, 1, 8'hBC, "R10 v4 status path pen");

        // R11 strobe with clearing read in the same cycle
        @(negedge clk);
        variant_i    = 3'd1;
        reg_idx_i    = 5'd16;
        stat_sel_i   = 1'b0;
        rd_en_i      = 1'b1;
        disp_addr_i  = 14'h1234;
        pen_strobe_i = 1'b1;
        exp_q.push_back(8'h2A);
        tag_q.push_back("R11 old pen hi");
        @(negedge clk);
        rd_en_i      = 1'b0;
        pen_strobe_i = 1'b0;
        rd(1, 0, 1, 8'h40, "R11 set wins");
        rd(3, 0, 0, 8'h12, "R11 R8 new pen hi");
        rd(3, 1, 0, 8'h34, "R11 R8 new pen lo");

        // R12 unused variant codes act as variant 0
        rd(5, 13, 0, 8'hA5, "R12 v5 reg13");
        rd(7, 5, 0, 8'h00, "R12 v7 idx5");
        rd(6, 16, 0, 8'h12, "R12 v6 pen hi");
        rd(6, 16, 1, 8'h00, "R12 v6 status zero");
        rd(3, 2, 0, 8'h40, "R12 no clear");

        repeat (3) @(negedge clk);
        // R3 no leftover or spurious data
        check("R3 queue drained", 8'(exp_q.size()), 8'h00);
        check("R3 idle valid", {7'b0, rd_valid_o}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule